// File: doc/BRIEF.md
# Symmetric Reset Debounce Filter

This block cleans up a reset line that may carry short spurious pulses. The filtered output holds its level until the incoming reset has shown the opposite level on N consecutive clock samples. Only then does it follow the input. The rule is the same in both directions, so the filter has hysteresis: a short high pulse cannot start a reset, and a short low dip cannot end one.

The output starts out asserted, because every register has an initial value. If the input stays low, the output lets go N samples later. A separate power-on input, `por_i`, resets the filter itself. It forces the output high in the same cycle it is raised, and it is not debounced. Once it drops, the filter is back in its asserted state with an empty count, so the output stays high for at least N more cycles. If the reset source is not synchronous to `clk_i`, set `ASYNC_IN=1` to put a two-stage synchronizer in front of the counter.

Top module: `rgf_filter`

## Requirements
- R1: While the output is low, it goes high on the clock edge that takes the N-th consecutive high sample of the input. It is visible from the following cycle.
- R2: While the output is high, it goes low on the clock edge that takes the N-th consecutive low sample of the input. The output never changes when the sampled input has not differed from it for N samples in a row.
- R3: At power-up the output is 1 (asserted). With the input held at 0 from time zero, the output reads 1 for the first N cycles (N+2 when ASYNC_IN=1) and 0 afterwards.
- R4: For N of 2 or more, an input pulse of one cycle, high or low, leaves the output unchanged.
- R5: In any cycle where `por_i` is 1, `rst_o` is 1 in that same cycle, with no clock edge needed.
- R6: After `por_i` returns to 0, the output stays 1 for at least N cycles. With the input at 0, it reads 0 exactly N cycles after release (N+2 when ASYNC_IN=1).
- R7: With ASYNC_IN=1, the input passes through two flip-flops that `por_i` presets to 1, which adds two cycles to every transition. With ASYNC_IN=0, the input is sampled directly.
- R8: With N=2, ASYNC_IN=0 and input 1,1,0,0,1,0,0,1,1,0,1,1 applied from power-up, the output reads 1,1,1,1,0,0,0,0,0,1,1,1.
- R9: The internal run counter stays below N at all times and is zero after every output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the filtered domain |
| por_i | input | 1 | Active-high reset of the filter itself; asserts the output immediately |
| rst_raw_i | input | 1 | Active-high reset to be filtered |
| rst_o | output | 1 | Filtered active-high reset |

## Verification
The bench builds two copies of the filter side by side. The first uses N=2 with direct sampling. This allows the short reference sequence to be replayed exactly, and it makes one-cycle pulses the longest events that must be rejected. The second uses N=5 with the two-flop synchronizer. This brings the extra two cycles of latency, the synchronizer preset by `por_i`, and runs between two and four cycles long within reach. Those runs must be rejected even though they are longer than a single glitch.

// File: rtl/rgf_pkg.sv
package rgf_pkg;

  // Bits needed to hold values 0..n
  function automatic int run_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/rgf_sync2.sv
// Two-stage synchronizer for a reset that is not timed to clk_i.
// Both stages are preset to the asserted level by power-on and by por_i.
module rgf_sync2 #(
  parameter int STAGES = rgf_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic raw_i,
  output logic smp_o
);

  logic [STAGES-1:0] pipe_q = '1;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], raw_i};
    end
  end

  assign smp_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rgf_hyst.sv
// Hysteresis core: counts consecutive samples that disagree with the held level.
module rgf_hyst #(
  parameter int N  = 2,
  parameter int CW = rgf_pkg::run_bits(N)
) (
  input  logic          clk_i,
  input  logic          por_i,
  input  logic          smp_i,
  output logic          state_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          state_q = 1'b1;
  logic [CW-1:0] cnt_q   = '0;
  logic          differ;
  logic          flip;

  assign differ = (smp_i != state_q);
  assign flip   = differ && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      state_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (flip) begin
      state_q <= ~state_q;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/rgf_filter.sv
// Reset debounce filter with symmetric hysteresis.
module rgf_filter #(
  parameter int N        = 2,
  parameter bit ASYNC_IN = 1'b0
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic rst_raw_i,
  output logic rst_o
);

  localparam int CW = rgf_pkg::run_bits(N);

  logic          smp;
  logic          state_q;
  logic [CW-1:0] cnt_q;

  generate
    if (ASYNC_IN) begin : g_sync
      rgf_sync2 #(.STAGES(rgf_pkg::SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .por_i (por_i),
        .raw_i (rst_raw_i),
        .smp_o (smp)
      );
    end else begin : g_direct
      assign smp = rst_raw_i;
    end
  endgenerate

  rgf_hyst #(.N(N), .CW(CW)) u_hyst (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .smp_i   (smp),
    .state_o (state_q),
    .cnt_o   (cnt_q)
  );

  assign rst_o = state_q | por_i;

endmodule

// File: rtl/rgf_filter_chk.sv
module rgf_filter_chk #(
  parameter int N  = 2,
  parameter int CW = rgf_pkg::run_bits(N)
) (
  input logic          clk_i,
  input logic          por_i,
  input logic          smp_i,
  input logic          state_i,
  input logic [CW-1:0] cnt_i,
  input logic          rst_o_i
);

  int unsigned hi_q = 0;
  int unsigned lo_q = 0;
  int unsigned cur_hi;
  int unsigned cur_lo;

  assign cur_hi = smp_i  ? ((hi_q >= N) ? N : hi_q + 1) : 0;
  assign cur_lo = !smp_i ? ((lo_q >= N) ? N : lo_q + 1) : 0;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      hi_q <= 0;
      lo_q <= 0;
    end else begin
      hi_q <= cur_hi;
      lo_q <= cur_lo;
    end
  end

  // R1
  hold_low_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!state_i && cur_hi < N) |=> !state_i);

  // R1
  rise_after_run_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!state_i && cur_hi >= N) |=> state_i);

  // R2
  hold_high_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (state_i && cur_lo < N) |=> state_i);

  // R2
  fall_after_run_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (state_i && cur_lo >= N) |=> !state_i);

  // R5
  por_immediate_chk: assert property (@(posedge clk_i) por_i |-> rst_o_i);

  // R6
  por_leaves_high_chk: assert property (@(posedge clk_i) por_i |=> (state_i && cnt_i == '0));

  // R9
  count_bound_chk: assert property (@(posedge clk_i) int'(cnt_i) < N);

  // R9
  count_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (state_i != smp_i && int'(cnt_i) == N - 1) |=> cnt_i == '0);

endmodule

bind rgf_filter rgf_filter_chk #(.N(N), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .por_i   (por_i),
  .smp_i   (smp),
  .state_i (state_q),
  .cnt_i   (cnt_q),
  .rst_o_i (rst_o)
);

// File: tb/sim_rgf_filter.sv
module sim_rgf_filter;

  localparam int N0 = 2;
  localparam int N1 = 5;

  logic clk = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic por = 1'b0;
  logic in0 = 1'b1;
  logic in1 = 1'b0;
  logic out0, out1;

  rgf_filter #(.N(N0), .ASYNC_IN(1'b0)) u0 (
    .clk_i(clk), .por_i(por), .rst_raw_i(in0), .rst_o(out0));
  rgf_filter #(.N(N1), .ASYNC_IN(1'b1)) u1 (
    .clk_i(clk), .por_i(por), .rst_raw_i(in1), .rst_o(out1));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Behavioural model per instance
  int   nn[2] = '{N0, N1};
  bit   as[2] = '{1'b0, 1'b1};
  logic m_st[2] = '{1'b1, 1'b1};
  int   m_run[2] = '{0, 0};
  logic m_s1[2] = '{1'b1, 1'b1};
  logic m_s2[2] = '{1'b1, 1'b1};

  task automatic check(input string tag, input int inst, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s inst%0d t=%0t got=%b exp=%b", tag, inst, $time, got, exp);
    end
  endtask

  task automatic model_edge(input int i, input logic din, input logic p);
    logic smp;
    smp = as[i] ? m_s2[i] : din;
    if (p) begin
      m_st[i] = 1'b1; m_run[i] = 0; m_s1[i] = 1'b1; m_s2[i] = 1'b1;
    end else begin
      if (as[i]) begin m_s2[i] = m_s1[i]; m_s1[i] = din; end
      if (smp == m_st[i]) m_run[i] = 0;
      else if (m_run[i] + 1 >= nn[i]) begin m_st[i] = ~m_st[i]; m_run[i] = 0; end
      else m_run[i] = m_run[i] + 1;
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model
  task automatic tick(input logic a, input logic b, input logic p, input string tag);
    @(negedge clk);
    in0 = a; in1 = b; por = p;
    #1;
    check(tag, 0, out0, m_st[0] | p);
    check(tag, 1, out1, m_st[1] | p);
    model_edge(0, a, p);
    model_edge(1, b, p);
  endtask

  logic [11:0] vin  = 12'b1100_1001_1011;
  logic [11:0] vexp = 12'b1111_0000_0111;

  initial begin
    void'($urandom(32'd1234));
    // R8 replay, R3 power-on on both instances
    for (int k = 0; k < 12; k++) begin
      tick(vin[11-k], 1'b0, 1'b0, "R8");
      check("R8", 0, out0, vexp[11-k]);
      if (k == 0) check("R3", 1, out1, 1'b1);
      if (k == 6) check("R3 R7", 1, out1, 1'b1);
      if (k == 7) check("R3 R7", 1, out1, 1'b0);
    end
    // R4: one-cycle low dip while asserted
    tick(1'b0, 1'b0, 1'b0, "R4");
    for (int k = 0; k < 3; k++) begin
      tick(1'b1, 1'b0, 1'b0, "R4");
      check("R4", 0, out0, 1'b1);
    end
    // R2: two low samples deassert
    tick(1'b0, 1'b0, 1'b0, "R2");
    tick(1'b0, 1'b0, 1'b0, "R2");
    tick(1'b0, 1'b0, 1'b0, "R2");
    check("R2", 0, out0, 1'b0);
    // R4: one-cycle high pulse while deasserted, both instances
    tick(1'b1, 1'b1, 1'b0, "R4");
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 1'b0, 1'b0, "R4");
      check("R4", 0, out0, 1'b0);
      check("R4", 1, out1, 1'b0);
    end
    // R1: two high samples assert
    tick(1'b1, 1'b0, 1'b0, "R1");
    tick(1'b1, 1'b0, 1'b0, "R1");
    check("R1", 0, out0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, "R1");
    check("R1", 0, out0, 1'b1);
    // R7/R4: a 4-cycle high run on the N=5 copy must be rejected
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b1, 1'b0, "R7");
    for (int k = 0; k < 6; k++) begin
      tick(1'b0, 1'b0, 1'b0, "R7");
      check("R7", 1, out1, 1'b0);
    end
    // R5: power-on reset takes effect in the same cycle
    tick(1'b0, 1'b0, 1'b1, "R5");
    check("R5", 0, out0, 1'b1);
    check("R5", 1, out1, 1'b1);
    tick(1'b0, 1'b0, 1'b1, "R5");
    // R6: hold-off after release
    for (int k = 0; k < 8; k++) begin
      tick(1'b0, 1'b0, 1'b0, "R6");
      if (k < N0) check("R6", 0, out0, 1'b1);
      if (k == N0) check("R6", 0, out0, 1'b0);
      if (k == N1 + 1) check("R6 R7", 1, out1, 1'b1);
      if (k == N1 + 2) check("R6 R7", 1, out1, 1'b0);
    end
    // Random runs with occasional power-on pulses
    begin
      logic a = 1'b0, b = 1'b0, p;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(3) == 0) a = ~a;
        if ($urandom_range(4) == 0) b = ~b;
        p = ($urandom_range(99) == 0);
        tick(a, b, p, "R1 R2 R4 R5");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule